// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level page table out of memory. A client presents an address and a read/write flag on a valid/ready request port. The walker reads the first-level entry, then the second-level entry, through a single memory read port, and returns either a physical address with its cache attribute bits or a fault.

The directory base comes in on a plain input and is sampled when the request is accepted. Its low 12 bits are ignored, so a directory always starts on a 4 KiB boundary. The top 10 address bits select a first-level entry, the next 10 bits select a second-level entry, and the low 12 bits pass straight into the result as the page offset. On a fault, the walker keeps the faulting virtual address and the access direction on two outputs until the next fault. Only one walk is in flight at a time.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to (dir_base_i AND 0xFFFFF000) + 4 * vaddr[31:22], using the base sampled when the request was accepted.
- R2: If bit 0 (present) of the first-level entry is 0, the walk ends in a fault after that single read, and no second read is issued.
- R3: The second read goes to (first-level entry AND 0xFFFFFFFE) + 4 * vaddr[21:12]. Only bit 0 of the entry is cleared, and the addition is a full 32-bit add.
- R4: If bit 0 of the second-level entry is 0, the walk ends in a fault.
- R5: The second-level entry grants permission as follows:
  - A read (req_write_i = 0) needs bit 1 set.
  - A write (req_write_i = 1) needs bit 2 set.
  - A request without the needed bit faults, exactly as a non-present page does.
- R6: A walk with no fault returns rsp_paddr_o = {entry[31:12], vaddr[11:0]} and rsp_attr_o = entry[8:3]. A faulting walk returns rsp_paddr_o = 0 and rsp_attr_o = 0.
- R7: On every fault, fault_vaddr_o and fault_write_o take the request's address and write flag. Walks that do not fault leave both outputs unchanged.
- R8: Handshake and timing:
  - req_ready_o is high only while idle. A request that arrives while a walk is in flight is ignored.
  - mem_rd_o and mem_addr_o hold steady until mem_rvalid_i, for any memory latency.
  - rsp_valid_o pulses for exactly one cycle, in the cycle after the last read completes.
- R9: After reset:
  - req_ready_o = 1.
  - rsp_valid_o = 0.
  - mem_rd_o = 0.
  - fault_vaddr_o = 0.
  - fault_write_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| dir_base_i | input | 32 | First-level table base, low 12 bits ignored |
| mem_rd_o | output | 1 | Table read request, held until mem_rvalid_i |
| mem_addr_o | output | 32 | Byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table entry read |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_paddr_o | output | 32 | Physical address, 0 on fault |
| rsp_attr_o | output | 6 | Cache and allocation bits 8:3 of the second-level entry |
| fault_vaddr_o | output | 32 | Virtual address of the latest fault |
| fault_write_o | output | 1 | Direction of the latest fault, 1 = write |

## Verification
A corrupted latched virtual address or level-2 base shows up on mem_addr_o at the very next table read, one or two cycles after acceptance. A wrong present or permission decision flips rsp_fault_o in the response cycle of that same walk. A lost fault capture shows up at the next non-faulting response, because fault_vaddr_o no longer matches the last faulting request. Sweeping the low indices under both directions covers every combination of entry bits 2:0, with several memory latencies. Keeping the request asserted, with different values, during a walk shows whether a busy walker ever takes a second request.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2, S_RSP} walk_state_e;
  localparam int unsigned PRESENT_BIT = 0;
  localparam int unsigned RD_BIT      = 1;
  localparam int unsigned WR_BIT      = 2;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned AW       = 32,
  parameter int unsigned IDX_W    = 10,
  parameter logic [AW-1:0] CLR_MASK = '0
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PAD_W = AW - IDX_W - 2;

  assign addr_o = (base_i & ~CLR_MASK) + {{PAD_W{1'b0}}, idx_i, 2'b00};
endmodule

// File: rtl/pt_leaf_check.sv
module pt_leaf_check
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ATTR_LO = 3,
  parameter int unsigned ATTR_W  = 6
) (
  input  logic [AW-1:0]     entry_i,
  input  logic              write_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic              fault_o,
  output logic [AW-1:0]     paddr_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int unsigned ATTR_HI = ATTR_LO + ATTR_W;

  logic perm_ok;
  logic unused_bits;

  assign unused_bits = ^entry_i[OFF_W-1:ATTR_HI];
  assign perm_ok = write_i ? entry_i[WR_BIT] : entry_i[RD_BIT];
  assign fault_o = !entry_i[PRESENT_BIT] || !perm_ok;
  assign paddr_o = fault_o ? '0 : {entry_i[AW-1:OFF_W], offset_i};
  assign attr_o  = fault_o ? '0 : entry_i[ATTR_LO +: ATTR_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned ATTR_LO = 3,
  parameter int unsigned ATTR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_vaddr_i,
  input  logic              req_write_i,
  input  logic [AW-1:0]     dir_base_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [AW-1:0]     mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [AW-1:0]     rsp_paddr_o,
  output logic [ATTR_W-1:0] rsp_attr_o,
  output logic [AW-1:0]     fault_vaddr_o,
  output logic              fault_write_o
);
  localparam logic [AW-1:0] DIR_CLR = AW'((64'd1 << OFF_W) - 1);
  localparam logic [AW-1:0] L2_CLR  = AW'(1);

  walk_state_e state_q;
  logic [AW-1:0] va_q, dir_q, l2_base_q;
  logic          wr_q;
  logic [AW-1:0] l1_addr, l2_addr;
  logic          leaf_fault;
  logic [AW-1:0] leaf_paddr;
  logic [ATTR_W-1:0] leaf_attr;

  pt_entry_addr #(.AW(AW), .IDX_W(IDX_W), .CLR_MASK(DIR_CLR)) u_l1_addr (
    .base_i(dir_q), .idx_i(va_q[AW-1 -: IDX_W]), .addr_o(l1_addr)
  );

  pt_entry_addr #(.AW(AW), .IDX_W(IDX_W), .CLR_MASK(L2_CLR)) u_l2_addr (
    .base_i(l2_base_q), .idx_i(va_q[OFF_W +: IDX_W]), .addr_o(l2_addr)
  );

  pt_leaf_check #(.AW(AW), .OFF_W(OFF_W), .ATTR_LO(ATTR_LO), .ATTR_W(ATTR_W)) u_leaf (
    .entry_i(mem_rdata_i), .write_i(wr_q), .offset_i(va_q[OFF_W-1:0]),
    .fault_o(leaf_fault), .paddr_o(leaf_paddr), .attr_o(leaf_attr)
  );

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_rd_o    = (state_q == S_L1) || (state_q == S_L2);
  assign mem_addr_o  = (state_q == S_L2) ? l2_addr : l1_addr;
  assign rsp_valid_o = (state_q == S_RSP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= S_IDLE;
      va_q          <= '0;
      wr_q          <= 1'b0;
      dir_q         <= '0;
      l2_base_q     <= '0;
      rsp_fault_o   <= 1'b0;
      rsp_paddr_o   <= '0;
      rsp_attr_o    <= '0;
      fault_vaddr_o <= '0;
      fault_write_o <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_vaddr_i;
          wr_q    <= req_write_i;
          dir_q   <= dir_base_i;
          state_q <= S_L1;
        end
        S_L1: if (mem_rvalid_i) begin
          if (!mem_rdata_i[PRESENT_BIT]) begin
            rsp_fault_o   <= 1'b1;
            rsp_paddr_o   <= '0;
            rsp_attr_o    <= '0;
            fault_vaddr_o <= va_q;
            fault_write_o <= wr_q;
            state_q       <= S_RSP;
          end else begin
            l2_base_q <= mem_rdata_i;
            state_q   <= S_L2;
          end
        end
        S_L2: if (mem_rvalid_i) begin
          rsp_fault_o <= leaf_fault;
          rsp_paddr_o <= leaf_paddr;
          rsp_attr_o  <= leaf_attr;
          if (leaf_fault) begin
            fault_vaddr_o <= va_q;
            fault_write_o <= wr_q;
          end
          state_q <= S_RSP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  a_r8_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || rsp_valid_o) |-> !req_ready_o);

  a_r8_read_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_rvalid_i) |=> (mem_rd_o && $stable(mem_addr_o)));

  a_r6_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_paddr_o == '0 && rsp_attr_o == '0));

  a_r7_hold_on_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> ($stable(fault_vaddr_o) && $stable(fault_write_o)));

  a_r2_l1_fault_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_L1 && mem_rvalid_i && !mem_rdata_i[PRESENT_BIT])
      |=> (rsp_valid_o && rsp_fault_o));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, dir_base = '0;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic req_ready, mem_rd, rsp_valid, rsp_fault, fault_write;
  logic [31:0] mem_addr, rsp_paddr, fault_vaddr;
  logic [5:0] rsp_attr;

  int checks = 0, fails = 0;
  int mem_lat = 0, nreads = 0, lat_cnt = 0;
  logic [31:0] rd_addr [2];
  logic [31:0] cur_dir = '0;
  logic [31:0] ef_va = '0;
  logic ef_wr = 1'b0;

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .dir_base_i(dir_base),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_paddr_o(rsp_paddr), .rsp_attr_o(rsp_attr), .fault_vaddr_o(fault_vaddr),
    .fault_write_o(fault_write)
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    logic [31:0] i;
    if (a >= cur_dir && a < cur_dir + 32'h1000) begin
      i = (a - cur_dir) >> 2;
      if (i % 4 == 3) return 32'h0;
      return (32'h0040_0000 + i * 32'h1000 + ((i % 2 == 1) ? 32'h10 : 32'h0))
             | 32'h1 | ((i % 3 == 0) ? 32'h2 : 32'h0);
    end
    return ((a * 32'h9E37) & 32'hFFFFF000) | ((a >> 2) & 32'h1FF);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        lat_cnt = 0;
      end else if (mem_rd) begin
        if (lat_cnt >= mem_lat) begin
          if (nreads < 2) rd_addr[nreads] = mem_addr;
          nreads++;
          mem_rdata = memf(mem_addr);
          mem_rvalid = 1'b1;
        end else lat_cnt++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic wr, input int lat,
                      input logic junk);
    logic [31:0] l1a, e1, l2a, e2, ep;
    logic ef, l1f;
    int n;
    l1a = cur_dir + {20'b0, va[31:22], 2'b00};
    e1  = memf(l1a);
    l1f = !e1[0];
    l2a = (e1 & 32'hFFFFFFFE) + {20'b0, va[21:12], 2'b00};
    e2  = memf(l2a);
    ef  = l1f || !e2[0] || (wr ? !e2[2] : !e2[1]);
    ep  = ef ? 32'h0 : {e2[31:12], va[11:0]};

    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    mem_lat = lat; nreads = 0; lat_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R8 ready low while busy", {31'b0, req_ready}, 32'h0);
    if (junk) begin
      req_vaddr = ~va; req_write = ~wr;
    end else req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(rsp_valid, "R8 response arrives", {31'b0, rsp_valid}, 32'h1);
    chk(rd_addr[0] == l1a, "R1 first-level read address", rd_addr[0], l1a);
    if (l1f) begin
      chk(nreads == 1, "R2 single read on level-1 fault", nreads, 1);
    end else begin
      chk(nreads == 2, "R3 two reads", nreads, 2);
      chk(rd_addr[1] == l2a, "R3 second-level read address", rd_addr[1], l2a);
    end
    chk(rsp_fault == ef, l1f ? "R2 level-1 fault" : "R4 R5 leaf fault",
        {31'b0, rsp_fault}, {31'b0, ef});
    chk(rsp_paddr == ep, "R6 physical address", rsp_paddr, ep);
    chk(rsp_attr == (ef ? 6'h0 : e2[8:3]), "R6 attributes", {26'b0, rsp_attr},
        {26'b0, (ef ? 6'h0 : e2[8:3])});
    if (ef) begin
      ef_va = va; ef_wr = wr;
    end
    chk(fault_vaddr == ef_va, "R7 fault address", fault_vaddr, ef_va);
    chk(fault_write == ef_wr, "R7 fault direction", {31'b0, fault_write}, {31'b0, ef_wr});
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] va;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R9 ready after reset", {31'b0, req_ready}, 32'h1);
    chk(!rsp_valid, "R9 no response after reset", {31'b0, rsp_valid}, 32'h0);
    chk(!mem_rd, "R9 no read after reset", {31'b0, mem_rd}, 32'h0);
    chk(fault_vaddr == 0 && !fault_write, "R9 fault outputs clear", fault_vaddr, 32'h0);

    for (int d = 0; d < 2; d++) begin
      dir_base = (d == 0) ? 32'h0001_0ABC : 32'h0002_0000;
      cur_dir  = dir_base & 32'hFFFFF000;
      for (int i1 = 0; i1 < 8; i1++)
        for (int i2 = 0; i2 < 8; i2++)
          for (int w = 0; w < 2; w++) begin
            va = {i1[9:0], i2[9:0], 12'((i1 * 32'h123 + i2 * 32'h31 + w * 32'h7) & 32'hFFF)};
            walk(va, w[0], (i1 + i2 + w) % 3, i2[0]);
          end
    end
    walk(32'hFFFF_FFFF, 1'b0, 1, 1'b1);
    walk({10'd1022, 10'd1023, 12'hFFF}, 1'b0, 0, 1'b0);
    walk({10'd1022, 10'd1023, 12'hFFF}, 1'b1, 2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule